// File: doc/BRIEF.md
# Power Delivery Frame Serializer

This block turns one Power Delivery request into a finished line waveform. A requester presents a 16-bit header, up to seven 32-bit data objects and a request kind, then raises `start` while `ready` is high. The block captures everything in that cycle and drives `line_out` with a biphase-mark-coded stream until the frame is complete, then pulses `done`.

A normal message carries a preamble, the start-of-packet ordered set, the header and the data objects as 4b/5b symbols, a CRC-32 over header and objects, and an end-of-packet symbol. A hard-reset request carries only the preamble and the reset ordered set. Every frame ends with one extra line transition so the far end sees a closing edge. The bit time is set by the `HALF_CLKS` parameter, the number of clocks in half a bit cell.

Top module: `pd_frame_encoder`

## Requirements
- R1: After reset, and at once when reset is applied in the middle of a frame, `line_out` is low, `busy` and `done` are low and `ready` is high.
- R2: `start` while `ready` is high is accepted; from the next cycle `busy` is high and `ready` low until the frame ends; `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R3: `start` while `busy` is high is ignored, and changing `header`, `data_objs` or `hard_rst_req` after acceptance has no effect on the frame being sent.
- R4: Each bit cell lasts 2*HALF_CLKS clocks and begins with a level change; a 1 adds a second change after HALF_CLKS clocks, a 0 adds none; `line_out` never changes while `busy` is low.
- R5: Every frame starts with 64 bits alternating 0,1,0,1,... beginning with 0.
- R6: A normal message continues with symbol 11000 three times and then 10001; every 5-bit symbol, read as a binary number, is sent least significant bit first.
- R7: Nibbles 0..F map to symbols 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R8: After the start ordered set come the header and then N data objects, N being header bits 14:12; object i is `data_objs[32*i+31:32*i]`; a 32-bit word is sent as low 16 bits then high 16 bits, each 16-bit value least significant nibble first.
- R9: After the objects comes the CRC-32 (reflected polynomial 0xEDB88320, start value all ones, final inversion) over header bits then object bits, each LSB first, sent as a 32-bit word as in R8.
- R10: The CRC is followed by symbol 01101, then one more level change; the line then holds for one full cell and `done` follows, with no other bits in the frame.
- R11: A hard-reset request (`hard_rst_req`=1) sends the preamble, symbol 00111 three times, symbol 11001 and the closing level change, and nothing from `header` or `data_objs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when `ready` is high |
| hard_rst_req | input | 1 | 1 = hard-reset frame, 0 = normal message |
| header | input | 16 | Message header; bits 14:12 give the object count |
| data_objs | input | 224 | Seven 32-bit data objects, object 0 in the low bits |
| ready | output | 1 | Block can accept a request |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| line_out | output | 1 | Biphase-mark-coded line level |

## Verification
On every cycle the assertions watch the handshake (acceptance raises `busy`, `done` lasts one cycle and coincides with the fall of `busy`), that the line is quiet while idle, and that every line change inside a frame lies one half or one whole cell after the previous one. What those changes mean can only be shown by the bench's frames: it decodes the waveform back into bits and compares preamble, ordered sets, symbol mapping, object order, CRC, end symbol, closing edge and the hard-reset layout with streams it builds itself, and it shows that requests and input changes during a frame leave the frame untouched.

// File: rtl/pdenc_pkg.sv
package pdenc_pkg;

   localparam int MAX_OBJS = 7;
   localparam int OBJ_W    = 32;
   localparam int HDR_W    = 16;
   localparam int SYM_W    = 5;
   localparam int PRE_BITS = 64;
   localparam int SYNC_LEN = 4;
   localparam int CRC_NIBS = 8;
   localparam int BODY_W   = HDR_W + MAX_OBJS * OBJ_W;
   localparam int CNT_LSB  = 12;

   // Line codes; bit 0 goes on the wire first
   localparam logic [SYM_W-1:0] SYM_SOP_A = 5'b11000;
   localparam logic [SYM_W-1:0] SYM_SOP_B = 5'b10001;
   localparam logic [SYM_W-1:0] SYM_HRA   = 5'b00111;
   localparam logic [SYM_W-1:0] SYM_HRB   = 5'b11001;
   localparam logic [SYM_W-1:0] SYM_END   = 5'b01101;

   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
   localparam logic [31:0] CRC_REFL = 32'hEDB8_8320;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_SYNC,
      PH_BODY,
      PH_CRC,
      PH_EOP,
      PH_TAIL
   } phase_t;

   function automatic logic [SYM_W-1:0] nib_to_sym(input logic [3:0] n);
      logic [SYM_W-1:0] s;
      case (n)
         4'h0: s = 5'b11110;
         4'h1: s = 5'b01001;
         4'h2: s = 5'b10100;
         4'h3: s = 5'b10101;
         4'h4: s = 5'b01010;
         4'h5: s = 5'b01011;
         4'h6: s = 5'b01110;
         4'h7: s = 5'b01111;
         4'h8: s = 5'b10010;
         4'h9: s = 5'b10011;
         4'hA: s = 5'b10110;
         4'hB: s = 5'b10111;
         4'hC: s = 5'b11010;
         4'hD: s = 5'b11011;
         4'hE: s = 5'b11100;
         default: s = 5'b11101;
      endcase
      return s;
   endfunction

   // Four reflected CRC steps, data bit 0 first
   function automatic logic [31:0] crc_step_nib(input logic [31:0] c, input logic [3:0] n);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 4; i++) begin
         if (r[0] ^ n[i]) r = (r >> 1) ^ CRC_REFL;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/pdenc_crc32.sv
module pdenc_crc32
   import pdenc_pkg::*;
#(
   parameter int NIBS_PER_UPD = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        upd,
   input  logic [3:0]  nib,
   output logic [31:0] crc_q
);

   logic [31:0] crc_r;
   logic [31:0] crc_next;

   generate
      if (NIBS_PER_UPD == 1) begin : g_single
         assign crc_next = crc_step_nib(crc_r, nib);
      end else begin : g_repeat
         // Same nibble folded several times; kept for wider variants
         always_comb begin
            crc_next = crc_r;
            for (int k = 0; k < NIBS_PER_UPD; k++) crc_next = crc_step_nib(crc_next, nib);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_r <= CRC_SEED;
      else if (clear)  crc_r <= CRC_SEED;
      else if (upd)    crc_r <= crc_next;
   end

   assign crc_q = crc_r;

endmodule

// File: rtl/pdenc_framer.sv
module pdenc_framer
   import pdenc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_hard,
   input  logic [BODY_W-1:0] load_body,
   input  logic [2:0]        load_cnt,
   input  logic              take,
   input  logic              finish,
   input  logic [31:0]       crc_val,
   output logic              crc_clr,
   output logic              crc_upd,
   output logic [3:0]        crc_nib,
   output logic              bit_o,
   output logic              final_o
);

   localparam int CW = $clog2(PRE_BITS);
   localparam int NW = $clog2(4 + 8 * MAX_OBJS);
   localparam logic [2:0] LAST_BIT = 3'(SYM_W - 1);

   phase_t             phase;
   logic [CW-1:0]      cnt;
   logic [2:0]         bidx;
   logic [SYM_W-1:0]   sym;
   logic               hard;
   logic [BODY_W-1:0]  body_sr;
   logic [31:0]        crc_sr;
   logic [NW-1:0]      nib_left;
   logic [31:0]        crc_fin;
   logic               sym_end;

   assign crc_fin = ~crc_val;
   assign sym_end = take && (bidx == LAST_BIT);

   assign crc_clr = load;
   assign crc_nib = body_sr[3:0];
   assign crc_upd = sym_end &&
                    ((phase == PH_SYNC && cnt == CW'(SYNC_LEN - 1) && !hard) ||
                     (phase == PH_BODY && nib_left != '0));

   always_comb begin
      case (phase)
         PH_PRE:                            bit_o = cnt[0];
         PH_SYNC, PH_BODY, PH_CRC, PH_EOP:  bit_o = sym[bidx];
         default:                           bit_o = 1'b0;
      endcase
   end

   assign final_o = (phase == PH_TAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         bidx     <= '0;
         sym      <= '0;
         hard     <= 1'b0;
         body_sr  <= '0;
         crc_sr   <= '0;
         nib_left <= '0;
      end else if (load) begin
         phase    <= PH_PRE;
         cnt      <= '0;
         bidx     <= '0;
         hard     <= load_hard;
         body_sr  <= load_body;
         nib_left <= NW'(3 + 8 * int'(load_cnt));
      end else if (finish) begin
         phase <= PH_IDLE;
      end else if (take) begin
         case (phase)
            PH_PRE: begin
               if (cnt == CW'(PRE_BITS - 1)) begin
                  phase <= PH_SYNC;
                  cnt   <= '0;
                  bidx  <= '0;
                  sym   <= hard ? SYM_HRA : SYM_SOP_A;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_SYNC, PH_BODY, PH_CRC, PH_EOP: begin
               if (bidx != LAST_BIT) begin
                  bidx <= bidx + 1'b1;
               end else begin
                  bidx <= '0;
                  case (phase)
                     PH_SYNC: begin
                        if (cnt == CW'(SYNC_LEN - 1)) begin
                           if (hard) begin
                              phase <= PH_TAIL;
                           end else begin
                              phase   <= PH_BODY;
                              sym     <= nib_to_sym(body_sr[3:0]);
                              body_sr <= body_sr >> 4;
                           end
                        end else begin
                           cnt <= cnt + 1'b1;
                           if (cnt == CW'(SYNC_LEN - 2)) sym <= hard ? SYM_HRB : SYM_SOP_B;
                           else                          sym <= hard ? SYM_HRA : SYM_SOP_A;
                        end
                     end
                     PH_BODY: begin
                        if (nib_left == '0) begin
                           phase  <= PH_CRC;
                           cnt    <= '0;
                           sym    <= nib_to_sym(crc_fin[3:0]);
                           crc_sr <= crc_fin >> 4;
                        end else begin
                           sym      <= nib_to_sym(body_sr[3:0]);
                           body_sr  <= body_sr >> 4;
                           nib_left <= nib_left - 1'b1;
                        end
                     end
                     PH_CRC: begin
                        if (cnt == CW'(CRC_NIBS - 1)) begin
                           phase <= PH_EOP;
                           sym   <= SYM_END;
                        end else begin
                           cnt    <= cnt + 1'b1;
                           sym    <= nib_to_sym(crc_sr[3:0]);
                           crc_sr <= crc_sr >> 4;
                        end
                     end
                     default: phase <= PH_TAIL;
                  endcase
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pdenc_bmc.sv
module pdenc_bmc #(
   parameter int HALF_CLKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic bit_i,
   input  logic final_i,
   output logic take_o,
   output logic fin_o,
   output logic line_o
);

   localparam int CELL_CLKS = 2 * HALF_CLKS;
   localparam int TW        = $clog2(CELL_CLKS + 1);
   localparam logic [TW-1:0] T_MID  = TW'(HALF_CLKS);
   localparam logic [TW-1:0] T_CELL = TW'(CELL_CLKS);

   logic          active;
   logic          cur_bit;
   logic          cur_final;
   logic          line_q;
   logic [TW-1:0] tcnt;
   logic          at_bound;

   assign at_bound = active && (tcnt == T_CELL);
   assign take_o   = at_bound && !cur_final;
   assign fin_o    = at_bound && cur_final;
   assign line_o   = line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         cur_bit   <= 1'b0;
         cur_final <= 1'b0;
         line_q    <= 1'b0;
         tcnt      <= '0;
      end else if (launch) begin
         active    <= 1'b1;
         cur_bit   <= 1'b0;
         cur_final <= 1'b0;
         tcnt      <= T_CELL;
      end else if (active) begin
         if (tcnt == T_CELL) begin
            if (cur_final) begin
               active <= 1'b0;
            end else begin
               line_q    <= ~line_q;
               cur_bit   <= bit_i;
               cur_final <= final_i;
               tcnt      <= TW'(1);
            end
         end else begin
            if (tcnt == T_MID && cur_bit) line_q <= ~line_q;
            tcnt <= tcnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pd_frame_encoder.sv
module pd_frame_encoder
   import pdenc_pkg::*;
#(
   parameter int HALF_CLKS = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      hard_rst_req,
   input  logic [HDR_W-1:0]          header,
   input  logic [MAX_OBJS*OBJ_W-1:0] data_objs,
   output logic                      ready,
   output logic                      busy,
   output logic                      done,
   output logic                      line_out
);

   initial begin
      if (HALF_CLKS < 1) $fatal(1, "HALF_CLKS must be at least 1");
   end

   logic              busy_q;
   logic              done_q;
   logic              accept;
   logic              take;
   logic              fin;
   logic              cur_bit;
   logic              cur_final;
   logic              crc_clr;
   logic              crc_upd;
   logic [3:0]        crc_nib;
   logic [31:0]       crc_val;
   logic [BODY_W-1:0] body_vec;

   assign accept = start && !busy_q;

   assign body_vec[HDR_W-1:0] = header;
   generate
      for (genvar i = 0; i < MAX_OBJS; i++) begin : g_obj
         assign body_vec[HDR_W + i*OBJ_W +: OBJ_W] = data_objs[i*OBJ_W +: OBJ_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= fin;
         if (accept)   busy_q <= 1'b1;
         else if (fin) busy_q <= 1'b0;
      end
   end

   pdenc_crc32 #(.NIBS_PER_UPD(1)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (crc_clr),
      .upd   (crc_upd),
      .nib   (crc_nib),
      .crc_q (crc_val)
   );

   pdenc_framer u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_hard (hard_rst_req),
      .load_body (body_vec),
      .load_cnt  (header[CNT_LSB +: 3]),
      .take      (take),
      .finish    (fin),
      .crc_val   (crc_val),
      .crc_clr   (crc_clr),
      .crc_upd   (crc_upd),
      .crc_nib   (crc_nib),
      .bit_o     (cur_bit),
      .final_o   (cur_final)
   );

   pdenc_bmc #(.HALF_CLKS(HALF_CLKS)) u_bmc (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (accept),
      .bit_i   (cur_bit),
      .final_i (cur_final),
      .take_o  (take),
      .fin_o   (fin),
      .line_o  (line_out)
   );

   assign busy  = busy_q;
   assign done  = done_q;
   assign ready = !busy_q;

endmodule

// File: rtl/pdenc_checker.sv
module pdenc_checker #(
   parameter int HALF_CLKS = 2
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic ready,
   input logic busy,
   input logic done,
   input logic line_out
);

   localparam int LIM = 2 * HALF_CLKS + 1;
   localparam int GW  = $clog2(LIM + 1);

   logic          line_d;
   logic          chg;
   logic          seen;
   logic [GW-1:0] gap;

   assign chg = (line_out != line_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_d <= 1'b0;
         seen   <= 1'b0;
         gap    <= '0;
      end else begin
         line_d <= line_out;
         if (chg)                gap <= GW'(1);
         else if (gap < GW'(LIM)) gap <= gap + 1'b1;
         if (!busy)     seen <= 1'b0;
         else if (chg)  seen <= 1'b1;
      end
   end

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> busy);

   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_fall_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(line_out));

   p_cell_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && chg && seen) |-> (gap == GW'(HALF_CLKS) || gap == GW'(2 * HALF_CLKS)));

endmodule

bind pd_frame_encoder pdenc_checker #(.HALF_CLKS(HALF_CLKS)) u_pdenc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .ready    (ready),
   .busy     (busy),
   .done     (done),
   .line_out (line_out)
);

// File: tb/pd_frame_encoder_bench.sv
module pd_frame_encoder_bench;
   import pdenc_pkg::*;

   localparam int H    = 2;
   localparam int CELL = 2 * H;
   // nibble F in the top five bits down to nibble 0 in the bottom five
   localparam logic [79:0] CODE_TAB = {
      5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
      5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic hard_rst_req = 1'b0;
   logic [15:0] header = '0;
   logic [MAX_OBJS*32-1:0] data_objs = '0;
   logic ready, busy, done, line_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   bit exp_q[$];
   bit got_q[$];
   int tr_t[$];

   always #10 clk = ~clk;

   pd_frame_encoder #(.HALF_CLKS(H)) u_pd_frame_encoder (
      .clk(clk), .rst_n(rst_n), .start(start), .hard_rst_req(hard_rst_req),
      .header(header), .data_objs(data_objs), .ready(ready), .busy(busy),
      .done(done), .line_out(line_out));

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [4:0] tb_code(input logic [3:0] n);
      return CODE_TAB[5*n +: 5];
   endfunction

   task automatic push_sym(input logic [4:0] s);
      for (int i = 0; i < 5; i++) exp_q.push_back(s[i]);
   endtask

   task automatic push_half(input logic [15:0] v);
      for (int k = 0; k < 4; k++) push_sym(tb_code(v[4*k +: 4]));
   endtask

   task automatic crc_bits(inout logic [31:0] c, input logic [31:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         logic fb;
         fb = c[0] ^ v[i];
         c = c >> 1;
         if (fb) c = c ^ 32'hEDB88320;
      end
   endtask

   task automatic build_expected(input bit hard, input logic [15:0] hdr,
                                 input logic [MAX_OBJS*32-1:0] objs);
      logic [31:0] c;
      int n;
      exp_q.delete();
      for (int i = 0; i < 64; i++) exp_q.push_back(bit'(i % 2));
      if (hard) begin
         push_sym(5'b00111); push_sym(5'b00111); push_sym(5'b00111); push_sym(5'b11001);
      end else begin
         push_sym(5'b11000); push_sym(5'b11000); push_sym(5'b11000); push_sym(5'b10001);
         push_half(hdr);
         c = 32'hFFFFFFFF;
         crc_bits(c, {16'h0, hdr}, 16);
         n = int'(hdr[14:12]);
         for (int w = 0; w < n; w++) begin
            push_half(objs[32*w +: 16]);
            push_half(objs[32*w + 16 +: 16]);
            crc_bits(c, objs[32*w +: 32], 32);
         end
         c = ~c;
         push_half(c[15:0]);
         push_half(c[31:16]);
         push_sym(5'b01101);
      end
   endtask

   task automatic cmp_region(input int lo, input int hi, input string tag, input string what);
      int bad_at = -1;
      int av = 0, ev = 0;
      for (int i = lo; i < hi; i++) begin
         if (bad_at < 0) begin
            if (i >= got_q.size()) begin
               bad_at = i; av = 2; ev = int'(exp_q[i]);
            end else if (got_q[i] != exp_q[i]) begin
               bad_at = i; av = int'(got_q[i]); ev = int'(exp_q[i]);
            end
         end
      end
      check(bad_at < 0, tag, $sformatf("%s bit %0d", what, bad_at), av, ev);
   endtask

   task automatic run_frame(input bit hard, input logic [15:0] hdr,
                            input logic [MAX_OBJS*32-1:0] objs,
                            input string body_tag, input bit disturb);
      int t = 0;
      int done_t = -1;
      logic prev;
      int bad = 0;
      int n;
      int body_end;
      build_expected(hard, hdr, objs);
      @(negedge clk);
      check(ready == 1'b1 && busy == 1'b0, "R2", "idle before request", {ready, busy}, 2'b10);
      hard_rst_req = hard; header = hdr; data_objs = objs; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1 && ready == 1'b0, "R2", "busy after accept", {ready, busy}, 2'b01);
      tr_t.delete();
      prev = line_out;
      while (done_t < 0 && t < 5000) begin
         if (disturb && t == 30) begin
            check(ready == 1'b0, "R3", "ready low mid-frame", ready, 0);
            start = 1'b1; header = ~hdr; hard_rst_req = ~hard; data_objs = ~objs;
         end
         if (disturb && t == 33) start = 1'b0;
         @(negedge clk);
         t++;
         if (line_out != prev) begin tr_t.push_back(t); prev = line_out; end
         if (done) done_t = t;
      end
      start = 1'b0;
      check(done_t >= 0, "R2", "done seen", done_t, 1);
      check(busy == 1'b0, "R2", "busy low with done", busy, 0);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R2", "done one cycle", {done, busy}, 0);
      if (tr_t.size() > 0)
         check(done_t - tr_t[tr_t.size()-1] == CELL, "R10", "closing cell length",
               done_t - tr_t[tr_t.size()-1], CELL);
      // decode intervals into bits; last change is the closing edge
      got_q.delete();
      n = tr_t.size();
      for (int i = 0; i < n - 1; ) begin
         int d = tr_t[i+1] - tr_t[i];
         if (d == CELL) begin
            got_q.push_back(1'b0); i++;
         end else if (d == H && i + 2 < n && tr_t[i+2] - tr_t[i+1] == H) begin
            got_q.push_back(1'b1); i += 2;
         end else begin
            bad++; i++;
         end
      end
      check(bad == 0, "R4", "cell timing", bad, 0);
      cmp_region(0, 64, "R5", "preamble");
      if (hard) begin
         cmp_region(64, 84, "R11", "reset ordered set");
         check(got_q.size() == exp_q.size(), "R11", "hard reset length", got_q.size(), exp_q.size());
      end else begin
         body_end = 84 + 20 + 40 * int'(hdr[14:12]);
         cmp_region(64, 84, "R6", "start ordered set");
         cmp_region(84, body_end, body_tag, "header and objects");
         cmp_region(body_end, body_end + 40, "R9", "crc");
         cmp_region(body_end + 40, body_end + 45, "R10", "end symbol");
         check(got_q.size() == exp_q.size(), "R10", "frame length", got_q.size(), exp_q.size());
      end
      if (disturb) cmp_region(0, exp_q.size(), "R3", "frame after late input change");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [MAX_OBJS*32-1:0] objs;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      check(line_out == 1'b0 && busy == 1'b0 && done == 1'b0 && ready == 1'b1,
            "R1", "state in reset", {line_out, busy, done, ready}, 4'b0001);
      rst_n = 1'b1;
      @(negedge clk);
      check(line_out == 1'b0 && busy == 1'b0 && ready == 1'b1, "R1", "state after reset",
            {line_out, busy, ready}, 3'b001);

      objs = '0;
      objs[31:0] = 32'h76543210;
      objs[63:32] = 32'hFEDCBA98;
      run_frame(1'b0, 16'h2DA5, objs, "R7", 1'b0);
      run_frame(1'b0, 16'h0C3A, objs, "R8", 1'b0);
      for (int w = 0; w < MAX_OBJS; w++) objs[32*w +: 32] = 32'h1000_0001 * (w + 3);
      run_frame(1'b0, 16'h7123, objs, "R8", 1'b0);
      run_frame(1'b1, 16'h7FFF, objs, "R8", 1'b0);
      run_frame(1'b0, 16'h3456, objs, "R8", 1'b1);
      run_frame(1'b1, 16'h1111, objs, "R8", 1'b1);

      for (int k = 0; k < 18; k++) begin
         logic [15:0] h;
         bit hr;
         h = 16'($urandom);
         hr = ($urandom % 5) == 0;
         for (int w = 0; w < MAX_OBJS; w++) objs[32*w +: 32] = $urandom;
         run_frame(hr, h, objs, "R8", (k % 6) == 5);
      end

      // reset in the middle of a frame
      @(negedge clk);
      header = 16'h7001; hard_rst_req = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (200) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(line_out == 1'b0 && busy == 1'b0 && done == 1'b0 && ready == 1'b1,
            "R1", "state after mid-frame reset", {line_out, busy, done, ready}, 4'b0001);
      rst_n = 1'b1;
      objs = '0;
      run_frame(1'b0, 16'h1ABC, objs, "R8", 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule